// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one memory request from a group of sixteen threads and breaks it into a short series of aligned off-chip transactions. Each thread supplies an active bit and the byte address of a 4-byte word. On every step the block finds the lowest-numbered thread that is still waiting. It takes the 128-byte aligned segment that holds that thread's word and gathers every waiting thread whose word lies in the same segment. It then shrinks the transaction to the smallest aligned 64-byte or 32-byte block that still covers all of those threads.

Each transaction goes out on a valid/ready stream. It carries a base address, a size code and the mask of threads it serves. When a transaction is accepted, the threads it serves are retired. Steps continue until no thread is left, and then a one-cycle done pulse marks the end of the request. Data return, the memory itself and merging of writes are handled elsewhere.

Top module: `coal_hw_top`

## Requirements
- R1: After reset, `txn_valid_o`, `done_o` and `busy_o` are all low.
- R2: Every transaction serves the lowest-numbered thread still pending. It serves every pending thread whose address lies in the same 128-byte aligned segment, and no others.
- R3: The size code is 0 for 32 bytes when the served threads touch a single aligned 32-byte quarter of the segment. It is 1 for 64 bytes when they touch a single aligned 64-byte half. Otherwise it is 2 for 128 bytes. `txn_base_o` is aligned to the chosen size and every served address lies inside the block.
- R4: Threads served by an accepted transaction are retired. Each active thread is served by exactly one transaction, and transactions come out in order of their leading thread.
- R5: While `txn_valid_o` is high and `txn_ready_i` is low, the transaction stays valid and its base, size and mask hold steady.
- R6: `done_o` is high for one cycle, in the cycle after the last transaction is accepted. `busy_o` is high from the cycle after a start until that done cycle.
- R7: A start pulse while `busy_o` is high is ignored: the request in flight completes unchanged and no extra transaction appears.
- R8: A start with an all-zero active mask issues no transaction and raises `done_o` in the cycle after the start.
- R9: Sixteen consecutive words beginning on a 64-byte boundary produce exactly one 64-byte transaction.
- R10: Inactive threads are never served, whatever their addresses.
- R11: With all threads active at words 116, 120, …, 176, the first transaction is 32 bytes at 96 serving threads 0–2. The second is 64 bytes at 128 serving threads 3–15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when not busy |
| act_mask_i | input | 16 | Active-thread mask, bit i for thread i |
| addr_i | input | 512 | Thread byte addresses, thread i in bits [32i+31:32i] |
| busy_o | output | 1 | A request is in progress |
| txn_valid_o | output | 1 | Transaction offered |
| txn_ready_i | input | 1 | Transaction accepted when high with valid |
| txn_base_o | output | 32 | Aligned base byte address |
| txn_size_o | output | 2 | Size code: 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txn_serve_o | output | 16 | Threads served by this transaction |
| done_o | output | 1 | One-cycle pulse at the end of a request |

## Verification
Assertions check on every cycle that the offered transaction covers the lowest pending thread, serves only pending threads, and has a base aligned to its size that encloses every served address. They also check that a stalled transaction holds steady, that accepted threads leave the pending set, and that starts while busy change nothing. Only the bench scenarios can show that the size is the smallest one possible, that the full sequence and count of transactions are right for concrete address patterns such as the 116-byte example and the stride-1 case, and that done arrives in the correct cycle, including for an empty mask.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned LG_QTR_BYTES = 5;
  localparam int unsigned LG_SEG_BYTES = 7;
  localparam int unsigned QTR_PER_SEG  = 1 << (LG_SEG_BYTES - LG_QTR_BYTES);

  typedef enum logic [1:0] {
    SZ_32B  = 2'd0,
    SZ_64B  = 2'd1,
    SZ_128B = 2'd2
  } seg_size_e;
endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int unsigned N_THR = 16,
  localparam int unsigned LG_N = $clog2(N_THR)
) (
  input  logic [N_THR-1:0] pend_i,
  output logic [LG_N-1:0]  lead_idx_o
);
  always_comb begin
    lead_idx_o = '0;
    for (int i = N_THR - 1; i >= 0; i--) begin
      if (pend_i[i]) lead_idx_o = LG_N'(i);
    end
  end
endmodule

// File: rtl/coal_seg_shrink.sv
module coal_seg_shrink
  import coal_pkg::*;
#(
  parameter int unsigned N_THR  = 16,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LG_N  = $clog2(N_THR),
  localparam int unsigned TAG_W = ADDR_W - LG_QTR_BYTES,
  localparam int unsigned QB    = LG_SEG_BYTES - LG_QTR_BYTES,
  localparam int unsigned SEG_W = TAG_W - QB
) (
  input  logic [N_THR-1:0]       pend_i,
  input  logic [N_THR*TAG_W-1:0] tag_i,
  input  logic [LG_N-1:0]        lead_idx_i,
  output logic [N_THR-1:0]       hit_o,
  output logic [ADDR_W-1:0]      base_o,
  output seg_size_e              size_o
);
  logic [TAG_W-1:0]       lead_tag;
  logic [SEG_W-1:0]       seg_sel;
  logic [QTR_PER_SEG-1:0] qtr_touch;
  logic [QTR_PER_SEG-1:0] qtr_of [N_THR];
  logic [QB-1:0]          qtr_idx;
  logic                   lo_half, hi_half;

  assign lead_tag = tag_i[lead_idx_i*TAG_W +: TAG_W];
  assign seg_sel  = lead_tag[TAG_W-1:QB];

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [TAG_W-1:0] tg;
    assign tg         = tag_i[t*TAG_W +: TAG_W];
    assign hit_o[t]   = pend_i[t] && (tg[TAG_W-1:QB] == seg_sel);
    assign qtr_of[t]  = hit_o[t] ? (QTR_PER_SEG'(1) << tg[QB-1:0]) : '0;
  end

  always_comb begin
    qtr_touch = '0;
    for (int t = 0; t < N_THR; t++) qtr_touch |= qtr_of[t];
  end

  always_comb begin
    qtr_idx = '0;
    for (int q = QTR_PER_SEG - 1; q >= 0; q--) begin
      if (qtr_touch[q]) qtr_idx = QB'(q);
    end
  end

  assign lo_half = |qtr_touch[QTR_PER_SEG/2-1:0];
  assign hi_half = |qtr_touch[QTR_PER_SEG-1:QTR_PER_SEG/2];

  always_comb begin
    if ($countones(qtr_touch) <= 1) begin
      size_o = SZ_32B;
      base_o = {seg_sel, qtr_idx, {LG_QTR_BYTES{1'b0}}};
    end else if (!(lo_half && hi_half)) begin
      size_o = SZ_64B;
      base_o = {seg_sel, hi_half, {(LG_QTR_BYTES + QB - 1){1'b0}}};
    end else begin
      size_o = SZ_128B;
      base_o = {seg_sel, {LG_SEG_BYTES{1'b0}}};
    end
  end
endmodule

// File: rtl/coal_hw_top.sv
module coal_hw_top
  import coal_pkg::*;
#(
  parameter int unsigned N_THR  = 16,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LG_N  = $clog2(N_THR),
  localparam int unsigned TAG_W = ADDR_W - LG_QTR_BYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [N_THR-1:0]        act_mask_i,
  input  logic [N_THR*ADDR_W-1:0] addr_i,
  output logic                    busy_o,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [ADDR_W-1:0]       txn_base_o,
  output logic [1:0]              txn_size_o,
  output logic [N_THR-1:0]        txn_serve_o,
  output logic                    done_o
);
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [N_THR-1:0]        pend_q, pend_d;
  logic [N_THR*ADDR_W-1:0] addr_q;
  logic                    done_q, done_d;
  logic                    start_ok, fire, addr_en;
  logic [N_THR*TAG_W-1:0]  tag_flat;
  logic [LG_N-1:0]         lead_idx;
  logic [N_THR-1:0]        hit;
  logic [ADDR_W-1:0]       base;
  seg_size_e               size;

  assign busy_o   = |pend_q;
  assign start_ok = start_i && !busy_o;
  assign fire     = txn_valid_o && txn_ready_i;
  assign addr_en  = start_ok;

  for (genvar t = 0; t < N_THR; t++) begin : g_tag
    assign tag_flat[t*TAG_W +: TAG_W] = addr_q[t*ADDR_W + LG_QTR_BYTES +: TAG_W];
  end

  coal_leader #(.N_THR(N_THR)) u_leader (
    .pend_i     (pend_q),
    .lead_idx_o (lead_idx)
  );

  coal_seg_shrink #(.N_THR(N_THR), .ADDR_W(ADDR_W)) u_shrink (
    .pend_i     (pend_q),
    .tag_i      (tag_flat),
    .lead_idx_i (lead_idx),
    .hit_o      (hit),
    .base_o     (base),
    .size_o     (size)
  );

  assign txn_valid_o = busy_o;
  assign txn_base_o  = base;
  assign txn_size_o  = size;
  assign txn_serve_o = hit;
  assign done_o      = done_q;

  always_comb begin
    pend_d = pend_q;
    done_d = 1'b0;
    if (start_ok) begin
      pend_d = act_mask_i;
      done_d = (act_mask_i == '0);
    end else if (fire) begin
      pend_d = pend_q & ~hit;
      done_d = (pend_d == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q <= '0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_i;
    end
  end

  logic [ADDR_W-1:0] size_mask;
  assign size_mask = (ADDR_W'(32) << txn_size_o) - ADDR_W'(1);

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    txn_valid_o |-> txn_size_o != 2'd3);  // R3
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    txn_valid_o |-> (txn_base_o & size_mask) == '0);  // R3
  AST_SERVE_LOWEST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    txn_valid_o |-> (txn_serve_o & (pend_q & (~pend_q + 1'b1))) != '0);  // R2
  AST_SERVE_PENDING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    txn_valid_o |-> (txn_serve_o & ~pend_q) == '0);  // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o)
      && $stable(txn_size_o) && $stable(txn_serve_o));  // R5
  AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fire |=> (pend_q & $past(txn_serve_o)) == '0);  // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o && !fire |=> $stable(pend_q));  // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !busy_o && !txn_valid_o);  // R6

  for (genvar t = 0; t < N_THR; t++) begin : g_chk
    AST_SERVE_INSIDE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      txn_valid_o && txn_serve_o[t] |->
        (addr_q[t*ADDR_W +: ADDR_W] & ~size_mask) == txn_base_o);  // R3
  end
endmodule

// File: tb/test_coal_hw_top.sv
`timescale 1ns/1ps
module test_coal_hw_top;
  localparam int NT = 16;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [NT-1:0]   act_mask_i;
  logic [NT*AW-1:0] addr_i;
  logic            busy_o, txn_valid_o, txn_ready_i, done_o;
  logic [AW-1:0]   txn_base_o;
  logic [1:0]      txn_size_o;
  logic [NT-1:0]   txn_serve_o;

  always #2.5 clk = ~clk;

  coal_hw_top i_coal_hw_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .act_mask_i(act_mask_i),
    .addr_i(addr_i), .busy_o(busy_o), .txn_valid_o(txn_valid_o),
    .txn_ready_i(txn_ready_i), .txn_base_o(txn_base_o), .txn_size_o(txn_size_o),
    .txn_serve_o(txn_serve_o), .done_o(done_o)
  );

  typedef struct {
    logic [AW-1:0] base;
    logic [1:0]    size;
    logic [NT-1:0] serve;
  } txn_t;

  txn_t        exp_q[$];
  int          checks = 0;
  int          errors = 0;
  int          seen_txn = 0;
  int          cyc = 0;
  int          rmode = 0;
  logic [AW-1:0] a_buf [NT];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // Reference: lowest pending leads, 128B segment, shrink by touched quarters
  task automatic build(input logic [NT-1:0] m, output int n);
    logic [NT-1:0] pend;
    pend = m;
    n = 0;
    while (pend != 0) begin
      int lead;
      logic [AW-1:0] seg;
      logic [3:0] q;
      txn_t it;
      lead = 0;
      while (!pend[lead]) lead++;
      seg = a_buf[lead] & ~32'h7F;
      q = '0;
      it.serve = '0;
      for (int i = 0; i < NT; i++) begin
        if (pend[i] && ((a_buf[i] & ~32'h7F) == seg)) begin
          it.serve[i] = 1'b1;
          q[a_buf[i][6:5]] = 1'b1;
        end
      end
      if ($countones(q) == 1) begin
        it.size = 2'd0;
        it.base = seg | (q[1] ? 32'h20 : 0) | (q[2] ? 32'h40 : 0) | (q[3] ? 32'h60 : 0);
      end else if (q[3:2] == 0) begin
        it.size = 2'd1; it.base = seg;
      end else if (q[1:0] == 0) begin
        it.size = 2'd1; it.base = seg | 32'h40;
      end else begin
        it.size = 2'd2; it.base = seg;
      end
      exp_q.push_back(it);
      pend &= ~it.serve;
      n++;
    end
  endtask

  task automatic pulse_start(input logic [NT-1:0] m);
    @(posedge clk); #1;
    for (int i = 0; i < NT; i++) addr_i[i*AW +: AW] = a_buf[i];
    act_mask_i = m;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag, output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!done_o && waited < 500);
    chk(done_o, {tag, " R6 done seen"}, done_o, 1);
    chk(exp_q.size() == 0, {tag, " R4 all expected txns issued"}, exp_q.size(), 0);
    @(negedge clk);
    chk(!done_o && !busy_o, {tag, " R6 done one cycle"}, {done_o, busy_o}, 0);
  endtask

  task automatic run_req(input logic [NT-1:0] m, input int mode, input string tag);
    int n, w;
    build(m, n);
    seen_txn = 0;
    rmode = mode;
    pulse_start(m);
    wait_done(tag, w);
    chk(seen_txn == n, {tag, " R4 txn count"}, seen_txn, n);
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    case (rmode)
      0: txn_ready_i = 1'b1;
      1: txn_ready_i = (cyc % 3) != 0;
      default: txn_ready_i = 1'b0;
    endcase
  end

  // Monitor: pops expected items as transactions are accepted
  logic          hold_prev = 1'b0;
  txn_t          held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        chk(txn_valid_o && txn_base_o == held.base && txn_size_o == held.size
            && txn_serve_o == held.serve, "R5 stall hold", txn_base_o, held.base);
      end
      if (txn_valid_o && txn_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected txn", txn_base_o, 0);
        end else begin
          txn_t e;
          e = exp_q.pop_front();
          chk(txn_serve_o == e.serve, "R2 served mask", txn_serve_o, e.serve);
          chk(txn_size_o == e.size, "R3 size code", txn_size_o, e.size);
          chk(txn_base_o == e.base, "R3 base", txn_base_o, e.base);
          seen_txn++;
        end
      end
      hold_prev = txn_valid_o && !txn_ready_i;
      held.base = txn_base_o; held.size = txn_size_o; held.serve = txn_serve_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, w;
    rst_n = 1'b0; start_i = 1'b0; act_mask_i = '0; addr_i = '0; txn_ready_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!txn_valid_o && !done_o && !busy_o, "R1 reset state", {txn_valid_o, done_o, busy_o}, 0);

    // R11: worked example
    for (int i = 0; i < NT; i++) a_buf[i] = 116 + 4 * i;
    build(16'hFFFF, n);
    chk(n == 2 && exp_q[0].base == 96 && exp_q[0].size == 0 && exp_q[0].serve == 16'h0007,
        "R11 first txn model", exp_q[0].base, 96);
    chk(exp_q[1].base == 128 && exp_q[1].size == 1 && exp_q[1].serve == 16'hFFF8,
        "R11 second txn model", exp_q[1].base, 128);
    exp_q.delete();
    run_req(16'hFFFF, 0, "R11 example");

    // R9: stride-1 from 64B boundary
    for (int i = 0; i < NT; i++) a_buf[i] = 32'h2040 + 4 * i;
    run_req(16'hFFFF, 0, "R9 stride1");
    chk(seen_txn == 1, "R9 one txn", seen_txn, 1);

    // R2/R4: each thread in its own segment, reverse order, stalled ready
    for (int i = 0; i < NT; i++) a_buf[i] = 32'h10000 - 128 * i + 4;
    run_req(16'hFFFF, 1, "R4 scattered");

    // R3: broadcast, 128B spread, two outer quarters
    for (int i = 0; i < NT; i++) a_buf[i] = 32'h3000_0010;
    run_req(16'hFFFF, 0, "R3 broadcast");
    for (int i = 0; i < NT; i++) a_buf[i] = 32'h4000 + 8 * i;
    run_req(16'hFFFF, 1, "R3 stride2");
    for (int i = 0; i < NT; i++) a_buf[i] = (i % 2) ? 32'h5060 : 32'h5000;
    run_req(16'hFFFF, 0, "R3 outer quarters");
    for (int i = 0; i < NT; i++) a_buf[i] = (i < 8) ? 32'h5840 + 4 * i : 32'h58C0;
    run_req(16'hFFFF, 1, "R3 upper half");

    // R10: inactive threads hold clashing addresses
    for (int i = 0; i < NT; i++) a_buf[i] = 32'h6000 + 4 * i;
    for (int i = 1; i < NT; i += 2) a_buf[i] = 32'h9999_0000 + 256 * i;
    run_req(16'h5555, 1, "R10 partial");

    // R8: empty mask
    exp_q.delete();
    seen_txn = 0;
    pulse_start(16'h0000);
    @(negedge clk);
    chk(done_o, "R8 done after empty start", done_o, 1);
    @(negedge clk);
    chk(!done_o && seen_txn == 0, "R8 no txn", seen_txn, 0);

    // R7: start while busy ignored
    for (int i = 0; i < NT; i++) a_buf[i] = 116 + 4 * i;
    build(16'hFFFF, n);
    seen_txn = 0;
    rmode = 2;
    pulse_start(16'hFFFF);
    for (int i = 0; i < NT; i++) a_buf[i] = 32'hF000_0000;
    pulse_start(16'h0001);
    @(negedge clk);
    chk(busy_o && txn_base_o == 96, "R7 first txn unchanged", txn_base_o, 96);
    rmode = 0;
    wait_done("R7 busy start", w);
    chk(seen_txn == 2, "R7 txn count", seen_txn, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule